// File: doc/BRIEF.md
# Transaction-Layer Memory Target

This block is a memory-mapped target at the transaction layer of a serial expansion link. Request packets arrive as a stream of 32-bit double words (DWs), one per accepted beat, framed by start-of-packet and end-of-packet flags. The block decodes the first header DW. It services single-DW memory writes and memory reads with a 32-bit address against an internal array of 64 words. Each read produces a completion-with-data packet on an outgoing DW stream.

The completion echoes the requester identity and tag of the read, so that it routes back to the caller and can be matched against the outstanding request. Only one read is in flight at a time: the request stream is held off while a completion is pending. All other packets are consumed to their end marker and then discarded. This covers four-DW headers, payload lengths other than one, other request types and badly framed packets.

Top module: `tlp_mem_target`

## Requirements
- R1: After reset, `rx_ready_o` is 1, `tx_valid_o` is 0, and every word of the array reads back as 0.
- R2: A packet with DW0 format bits [30:29]=10, type bits [28:24]=00000 and length bits [9:0]=1 is a write. Its DW2 address selects word `addr[7:2]`, and address bits above 7 are ignored. DW3 is the data, and end-of-packet is on DW3.
- R3: A write updates only the byte lanes whose first-DW byte enables (DW1 bits [3:0], bit n for byte n) are 1.
- R4: A packet with format 00, type 00000 and length 1, ending on DW2, is a read. It yields exactly four completion beats, with `tx_sop_o` on the first beat only and `tx_eop_o` on the fourth beat only.
- R5: Completion DW0 is 0x4A000001 (format 10, type 01010, length 1). DW1 is {completer ID, status 000, 0, byte count 4}, which is 0x01000004 for the default completer ID 0x0100.
- R6: Completion DW2 is {requester ID from request DW1[31:16], tag from request DW1[15:8], 0, {addr[6:2],00}}. DW3 holds the addressed word.
- R7: `rx_ready_o` falls in the cycle after a read's address DW is accepted. It rises again in the cycle after the last completion beat is accepted.
- R8: While `tx_valid_o` is 1 and `tx_ready_i` is 0, the outgoing beat is held unchanged.
- R9: Packets with a four-DW header (format 01 or 11) are drained with no write and no completion.
- R10: Packets with a length field other than 1 are drained with no write and no completion.
- R11: Packets with a type other than 00000 are drained with no write and no completion.
- R12: A read whose address DW is accepted after a write's data DW returns the written value.
- R13: A write or read whose end-of-packet does not fall on its expected beat (DW3 for a write, DW2 for a read) has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 32 | Incoming request DW |
| rx_valid_i | input | 1 | Incoming DW valid |
| rx_sop_i | input | 1 | First DW of a request |
| rx_eop_i | input | 1 | Last DW of a request |
| rx_ready_o | output | 1 | Block accepts an incoming DW |
| tx_data_o | output | 32 | Outgoing completion DW |
| tx_valid_o | output | 1 | Outgoing DW valid |
| tx_sop_o | output | 1 | First DW of a completion |
| tx_eop_o | output | 1 | Last DW of a completion |
| tx_ready_i | input | 1 | Downstream accepts the outgoing DW |

## Verification
Two results have fixed timing. A write takes effect at the edge that accepts its data DW. A completion's first beat is valid one cycle after the edge that accepts the read's address DW, and `rx_ready_o` is low from that same cycle. Each further completion beat follows one cycle after its predecessor is taken, and ready returns one cycle after the fourth beat is taken. The bench drives inputs just after the rising edge and compares outputs at the falling edge against a behavioural model. The model registers a handshake at the falling edge before the edge that commits it, so every expected value is due at the next falling edge. Dropped packets are checked through the absence of completion beats and through later reads of the words they could have touched.

// File: rtl/tlp_tgt_pkg.sv
package tlp_tgt_pkg;
  localparam int DW_W = 32;

  localparam logic [1:0] FMT_3DW_NODATA = 2'b00;
  localparam logic [1:0] FMT_3DW_DATA   = 2'b10;
  localparam logic [4:0] TYPE_MEM       = 5'b00000;
  localparam logic [4:0] TYPE_CPL       = 5'b01010;
  localparam logic [2:0] CPL_STAT_OK    = 3'b000;
  localparam logic [11:0] CPL_BYTES     = 12'd4;

  typedef enum logic [1:0] {REQ_NONE, REQ_WR, REQ_RD} req_kind_e;

  typedef struct packed {
    logic [15:0] rid;
    logic [7:0]  tag;
    logic [6:0]  lo_addr;
  } cpl_ctx_t;

  function automatic req_kind_e classify(logic [DW_W-1:0] dw0);
    logic [1:0] fmt;
    logic [4:0] typ;
    logic [9:0] len;
    fmt = dw0[30:29];
    typ = dw0[28:24];
    len = dw0[9:0];
    if (typ != TYPE_MEM || len != 10'd1) return REQ_NONE;
    if (fmt == FMT_3DW_DATA)   return REQ_WR;
    if (fmt == FMT_3DW_NODATA) return REQ_RD;
    return REQ_NONE;
  endfunction
endpackage

// File: rtl/tlp_rx_decode.sv
module tlp_rx_decode
  import tlp_tgt_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DW_W-1:0]  rx_data_i,
  input  logic             rx_valid_i,
  input  logic             rx_sop_i,
  input  logic             rx_eop_i,
  input  logic             rx_ready_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [3:0]       wr_be_o,
  output logic [DW_W-1:0]  wr_data_o,
  output logic             rd_en_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output cpl_ctx_t         ctx_o
);
  localparam int BEAT_W = 3;
  localparam logic [BEAT_W-1:0] BEAT_MAX = BEAT_W'(4);
  localparam logic [BEAT_W-1:0] BEAT_HDR = BEAT_W'(0);
  localparam logic [BEAT_W-1:0] BEAT_ID  = BEAT_W'(1);
  localparam logic [BEAT_W-1:0] BEAT_ADR = BEAT_W'(2);
  localparam logic [BEAT_W-1:0] BEAT_DAT = BEAT_W'(3);

  logic              acc;
  logic [BEAT_W-1:0] beat_q, beat_cur;
  req_kind_e         kind_q, kind_cur;
  logic [15:0]       rid_q;
  logic [7:0]        tag_q;
  logic [3:0]        be_q;
  logic [IDX_W-1:0]  idx_q;

  assign acc      = rx_valid_i & rx_ready_i;
  // a start marker always restarts the parse
  assign beat_cur = rx_sop_i ? BEAT_HDR : beat_q;
  assign kind_cur = (beat_cur == BEAT_HDR) ? classify(rx_data_i) : kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= BEAT_HDR;
      kind_q <= REQ_NONE;
      rid_q  <= '0;
      tag_q  <= '0;
      be_q   <= '0;
      idx_q  <= '0;
    end else if (acc) begin
      if (rx_eop_i)                  beat_q <= BEAT_HDR;
      else if (beat_cur != BEAT_MAX) beat_q <= beat_cur + BEAT_W'(1);
      kind_q <= kind_cur;
      if (beat_cur == BEAT_ID) begin
        rid_q <= rx_data_i[31:16];
        tag_q <= rx_data_i[15:8];
        be_q  <= rx_data_i[3:0];
      end
      if (beat_cur == BEAT_ADR) idx_q <= rx_data_i[IDX_W+1:2];
    end
  end

  assign wr_en_o   = acc && rx_eop_i && beat_cur == BEAT_DAT && kind_cur == REQ_WR;
  assign wr_idx_o  = idx_q;
  assign wr_be_o   = be_q;
  assign wr_data_o = rx_data_i;

  assign rd_en_o   = acc && rx_eop_i && beat_cur == BEAT_ADR && kind_cur == REQ_RD;
  assign rd_idx_o  = rx_data_i[IDX_W+1:2];
  assign ctx_o     = '{rid: rid_q, tag: tag_q, lo_addr: {rx_data_i[6:2], 2'b00}};

  // R2
  wr_framing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> rx_valid_i && rx_eop_i && !rx_sop_i);

  // R7
  rd_holdoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> !rx_ready_i);
endmodule

// File: rtl/tlp_word_store.sv
module tlp_word_store
  import tlp_tgt_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [3:0]       wr_be_i,
  input  logic [DW_W-1:0]  wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW_W-1:0]  rd_data_o
);
  localparam int LANES = DW_W / 8;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [7:0] lane_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) lane_q[i] <= '0;
      end else if (wr_en_i && wr_be_i[b]) begin
        lane_q[wr_idx_i] <= wr_data_i[8*b +: 8];
      end
    end

    assign rd_data_o[8*b +: 8] = lane_q[rd_idx_i];
  end
endmodule

// File: rtl/tlp_cpl_gen.sv
module tlp_cpl_gen
  import tlp_tgt_pkg::*;
#(
  parameter logic [15:0] CPL_ID = 16'h0100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  cpl_ctx_t        ctx_i,
  input  logic [DW_W-1:0] data_i,
  output logic [DW_W-1:0] tx_data_o,
  output logic            tx_valid_o,
  output logic            tx_sop_o,
  output logic            tx_eop_o,
  input  logic            tx_ready_i,
  output logic            busy_o
);
  localparam int BEATS = 4;
  localparam int CNT_W = $clog2(BEATS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

  localparam logic [DW_W-1:0] HDR0 = {1'b0, FMT_3DW_DATA, TYPE_CPL, 14'h0, 10'd1};
  localparam logic [DW_W-1:0] HDR1 = {CPL_ID, CPL_STAT_OK, 1'b0, CPL_BYTES};

  logic             busy_q;
  logic [CNT_W-1:0] beat_q;
  cpl_ctx_t         ctx_q;
  logic [DW_W-1:0]  data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      ctx_q  <= '0;
      data_q <= '0;
    end else if (!busy_q) begin
      if (load_i) begin
        busy_q <= 1'b1;
        beat_q <= '0;
        ctx_q  <= ctx_i;
        data_q <= data_i;
      end
    end else if (tx_ready_i) begin
      if (beat_q == LAST) busy_q <= 1'b0;
      beat_q <= beat_q + CNT_W'(1);
    end
  end

  always_comb begin
    unique case (beat_q)
      2'd0:    tx_data_o = HDR0;
      2'd1:    tx_data_o = HDR1;
      2'd2:    tx_data_o = {ctx_q.rid, ctx_q.tag, 1'b0, ctx_q.lo_addr};
      default: tx_data_o = data_q;
    endcase
  end

  assign tx_valid_o = busy_q;
  assign tx_sop_o   = busy_q && beat_q == '0;
  assign tx_eop_o   = busy_q && beat_q == LAST;
  assign busy_o     = busy_q;

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_sop_o));

  // R4
  sop_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> tx_sop_o && !tx_eop_o);

  // R4
  eop_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_eop_o && tx_ready_i |=> !tx_valid_o);

  // R4
  sop_eop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_sop_o && tx_eop_o));
endmodule

// File: rtl/tlp_mem_target.sv
module tlp_mem_target
  import tlp_tgt_pkg::*;
#(
  parameter int          DEPTH  = 64,
  parameter logic [15:0] CPL_ID = 16'h0100
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] rx_data_i,
  input  logic        rx_valid_i,
  input  logic        rx_sop_i,
  input  logic        rx_eop_i,
  output logic        rx_ready_o,
  output logic [31:0] tx_data_o,
  output logic        tx_valid_o,
  output logic        tx_sop_o,
  output logic        tx_eop_o,
  input  logic        tx_ready_i
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             wr_en, rd_en, cpl_busy;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [3:0]       wr_be;
  logic [DW_W-1:0]  wr_data, rd_data;
  cpl_ctx_t         ctx;

  assign rx_ready_o = !cpl_busy;

  tlp_rx_decode #(.IDX_W(IDX_W)) i_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_data_i  (rx_data_i),
    .rx_valid_i (rx_valid_i),
    .rx_sop_i   (rx_sop_i),
    .rx_eop_i   (rx_eop_i),
    .rx_ready_i (rx_ready_o),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_be_o    (wr_be),
    .wr_data_o  (wr_data),
    .rd_en_o    (rd_en),
    .rd_idx_o   (rd_idx),
    .ctx_o      (ctx)
  );

  tlp_word_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_be_i   (wr_be),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data)
  );

  tlp_cpl_gen #(.CPL_ID(CPL_ID)) i_cpl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (rd_en),
    .ctx_i      (ctx),
    .data_i     (rd_data),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o),
    .tx_sop_o   (tx_sop_o),
    .tx_eop_o   (tx_eop_o),
    .tx_ready_i (tx_ready_i),
    .busy_o     (cpl_busy)
  );

  // R7
  rd_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |-> !tx_valid_o);
endmodule

// File: tb/test_tlp_mem_target.sv
module test_tlp_mem_target;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] rx_data_i = '0;
  logic        rx_valid_i = 1'b0, rx_sop_i = 1'b0, rx_eop_i = 1'b0;
  logic        rx_ready_o;
  logic [31:0] tx_data_o;
  logic        tx_valid_o, tx_sop_o, tx_eop_o;
  logic        tx_ready_i = 1'b1;

  always #4 clk_i = ~clk_i;

  tlp_mem_target i_tlp_mem_target (.*);

  int checks = 0, fails = 0;
  logic [31:0] pkt [8];
  logic [31:0] exp_q [$];
  logic [31:0] mem_m [64];
  logic [31:0] last_rd = '0;
  int  m_beat = 0, m_kind = 0;
  logic [15:0] m_rid;
  logic [7:0]  m_tag;
  logic [3:0]  m_be;
  int  m_idx = 0;
  bit  stall_mode = 0;
  int  rdy_cnt = 0;
  bit  prev_stall = 0;
  logic [31:0] prev_data = '0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] dw0(logic [1:0] fmt, logic [4:0] ty, logic [9:0] len);
    return {1'b0, fmt, ty, 14'h0, len};
  endfunction

  function automatic logic [31:0] dw1(logic [15:0] rid, logic [7:0] tag, logic [3:0] be);
    return {rid, tag, 4'h0, be};
  endfunction

  // behavioural reference of the request stream
  task automatic model_beat(logic [31:0] d, bit sop, bit eop);
    int b;
    b = sop ? 0 : m_beat;
    if (b == 0)
      m_kind = (d[28:24] == 5'd0 && d[9:0] == 10'd1) ?
               (d[30:29] == 2'b10 ? 1 : (d[30:29] == 2'b00 ? 2 : 0)) : 0;
    if (b == 1) begin m_rid = d[31:16]; m_tag = d[15:8]; m_be = d[3:0]; end
    if (b == 2) begin
      m_idx = int'(d[7:2]);
      if (m_kind == 2 && eop) begin
        exp_q.push_back(32'h4A00_0001);
        exp_q.push_back(32'h0100_0004);
        exp_q.push_back({m_rid, m_tag, 1'b0, d[6:2], 2'b00});
        exp_q.push_back(mem_m[d[7:2]]);
      end
    end
    if (b == 3 && m_kind == 1 && eop)
      for (int k = 0; k < 4; k++)
        if (m_be[k]) mem_m[m_idx][8*k +: 8] = d[8*k +: 8];
    m_beat = eop ? 0 : (b < 4 ? b + 1 : 4);
  endtask

  always @(negedge clk_i) if (rst_ni) begin
    // R7 ready low exactly while a completion is owed
    chk(rx_ready_o == (exp_q.size() == 0), "R7 ready", 32'(rx_ready_o), 32'(exp_q.size() == 0));
    chk(tx_valid_o == (exp_q.size() != 0), "R4 valid", 32'(tx_valid_o), 32'(exp_q.size() != 0));
    if (prev_stall)
      chk(tx_valid_o && tx_data_o == prev_data, "R8 hold", tx_data_o, prev_data);
    if (tx_valid_o && exp_q.size() != 0) begin
      automatic int ix = 4 - exp_q.size();
      chk(tx_data_o == exp_q[0], ix < 2 ? "R5 hdr" : "R6 dw", tx_data_o, exp_q[0]);
      chk(tx_sop_o == (ix == 0), "R4 sop", 32'(tx_sop_o), 32'(ix == 0));
      chk(tx_eop_o == (ix == 3), "R4 eop", 32'(tx_eop_o), 32'(ix == 3));
      if (tx_ready_i) begin
        if (ix == 3) last_rd = tx_data_o;
        void'(exp_q.pop_front());
      end
    end
    prev_stall = tx_valid_o && !tx_ready_i;
    prev_data  = tx_data_o;
    if (rx_valid_i && rx_ready_o) model_beat(rx_data_i, rx_sop_i, rx_eop_i);
  end

  always @(posedge clk_i) begin
    #1;
    rdy_cnt++;
    tx_ready_i = !stall_mode || (rdy_cnt % 3 == 0);
  end

  task automatic send(int n);
    for (int i = 0; i < n; i++) begin
      rx_data_i = pkt[i]; rx_sop_i = (i == 0); rx_eop_i = (i == n - 1); rx_valid_i = 1'b1;
      @(negedge clk_i);
      while (!rx_ready_o) @(negedge clk_i);
      @(posedge clk_i); #1;
    end
    rx_valid_i = 1'b0; rx_sop_i = 1'b0; rx_eop_i = 1'b0;
  endtask

  task automatic wr(logic [31:0] addr, logic [31:0] data, logic [3:0] be);
    pkt[0] = dw0(2'b10, 5'd0, 10'd1); pkt[1] = dw1(16'h00A1, 8'h11, be);
    pkt[2] = addr; pkt[3] = data;
    send(4);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(posedge clk_i); #2;
      if (!tx_valid_o && exp_q.size() == 0) break;
    end
  endtask

  task automatic rd(logic [31:0] addr, logic [15:0] rid, logic [7:0] tag, logic [31:0] exp, string tag_s);
    last_rd = 32'hDEAD_DEAD;
    pkt[0] = dw0(2'b00, 5'd0, 10'd1); pkt[1] = dw1(rid, tag, 4'hF); pkt[2] = addr;
    send(3);
    wait_idle();
    chk(last_rd == exp, tag_s, last_rd, exp);
  endtask

  task automatic no_cpl(string tag_s);
    repeat (3) @(posedge clk_i);
    #2 chk(!tx_valid_o, tag_s, 32'(tx_valid_o), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem_m[i] = '0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(rx_ready_o == 1'b1, "R1 ready", 32'(rx_ready_o), 32'd1);
    chk(tx_valid_o == 1'b0, "R1 valid", 32'(tx_valid_o), 32'd0);
    @(posedge clk_i); #1;
    rd(32'h0000_0024, 16'h0001, 8'h01, 32'h0, "R1 array");

    // R2 R12 write then read, high address bits ignored
    wr(32'h0000_0010, 32'hA5A5_1234, 4'hF);
    rd(32'h0000_0010, 16'h1234, 8'h07, 32'hA5A5_1234, "R12 rdback");
    wr(32'h1234_03FC, 32'h0BAD_F00D, 4'hF);
    rd(32'h0000_00FC, 16'hCAFE, 8'hFF, 32'h0BAD_F00D, "R2 alias");

    // R3 byte lanes 0 and 2
    wr(32'h0000_0010, 32'hFFFF_FFFF, 4'h5);
    rd(32'h0000_0010, 16'h0002, 8'h02, 32'hA5FF_12FF, "R3 lanes");

    // R9 four-DW header write and read
    pkt[0] = dw0(2'b11, 5'd0, 10'd1); pkt[1] = dw1(16'h1, 8'h1, 4'hF);
    pkt[2] = 32'h0; pkt[3] = 32'h10; pkt[4] = 32'h1111_1111;
    send(5);
    pkt[0] = dw0(2'b01, 5'd0, 10'd1); pkt[3] = 32'h10;
    send(4);
    no_cpl("R9 nocpl");
    rd(32'h0000_0010, 16'h0003, 8'h03, 32'hA5FF_12FF, "R9 nowrite");

    // R10 length 2 write and read
    pkt[0] = dw0(2'b10, 5'd0, 10'd2); pkt[1] = dw1(16'h1, 8'h1, 4'hF);
    pkt[2] = 32'h10; pkt[3] = 32'h2222_2222; pkt[4] = 32'h3333_3333;
    send(5);
    pkt[0] = dw0(2'b00, 5'd0, 10'd2); send(3);
    no_cpl("R10 nocpl");
    rd(32'h0000_0010, 16'h0004, 8'h04, 32'hA5FF_12FF, "R10 nowrite");

    // R11 other type
    pkt[0] = dw0(2'b10, 5'h04, 10'd1); pkt[1] = dw1(16'h1, 8'h1, 4'hF);
    pkt[2] = 32'h10; pkt[3] = 32'h4444_4444;
    send(4);
    pkt[0] = dw0(2'b00, 5'h04, 10'd1); send(3);
    no_cpl("R11 nocpl");
    rd(32'h0000_0010, 16'h0005, 8'h05, 32'hA5FF_12FF, "R11 nowrite");

    // R13 truncated write, over-long read
    pkt[0] = dw0(2'b10, 5'd0, 10'd1); pkt[1] = dw1(16'h1, 8'h1, 4'hF); pkt[2] = 32'h10;
    send(3);
    pkt[0] = dw0(2'b00, 5'd0, 10'd1); pkt[3] = 32'h0;
    send(4);
    no_cpl("R13 nocpl");
    rd(32'h0000_0010, 16'h0006, 8'h06, 32'hA5FF_12FF, "R13 nowrite");

    // R8 back-pressure with back-to-back reads
    stall_mode = 1;
    wr(32'h0000_0040, 32'h1357_9BDF, 4'hF);
    rd(32'h0000_0040, 16'hABCD, 8'h5A, 32'h1357_9BDF, "R8 stall rd");
    rd(32'h0000_007C, 16'h4321, 8'hA5, 32'h0, "R6 lo addr");
    stall_mode = 0;
    wait_idle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule